// File: doc/BRIEF.md
# Fuse Bit Program-Verify Sequencer

This block writes one byte value into a one-time-programmable fuse array. It does this by issuing single-bit program pulses and byte reads to a fuse controller. A job starts with a read of the target byte. If every bit requested as 1 already reads as 1, the job ends at once. Otherwise each requested bit is handled in turn, from the lowest index to the highest:

- The byte is read again. A bit that is already blown is passed over.
- A bit that is still 0 receives a guaranteed minimum number of program pulses.
- After that minimum, the bit is read back after every further pulse, until it reads 1 or the pulse limit is used up.

A final read then confirms the whole request.

Commands leave on a valid/ready channel. The sequencer raises `cmd_valid` and holds `cmd_prog`, `cmd_bit` and `cmd_addr` unchanged until `cmd_ready` is seen high at a clock edge. After that transfer it issues nothing more until the controller returns one `rsp_valid` pulse, which marks the command as complete. For a read, `rsp_data` carries the byte in that same cycle. A `rsp_valid` that arrives with no command outstanding is ignored. The controller applies back-pressure only through `cmd_ready`, and the sequencer is always ready for the response.

The host pulses `start` with an address and a value. It then waits for the one-cycle `done` pulse and reads `error`, which holds its value until the next accepted start.

Top module: `fuse_prog_seq`

## Requirements
- R1: Each job begins with a byte read (`cmd_prog`=0). If no requested 1 bit reads as 0, `done` pulses with `error` low after that single read, and no program command is issued.
- R2: Bits are worked on in ascending index order, and a program command (`cmd_prog`=1) names only a bit index `cmd_bit` that is 1 in the requested value.
- R3: Before a requested bit is pulsed, the byte is read. If that bit reads 1, it receives no pulse.
- R4: A bit receives program pulses one command at a time, never more than MAX_PULSES (20 by default).
- R5: No verify read follows a bit's pulses until MIN_PULSES (4 by default) have completed. From then on, a read follows every pulse, and the bit is finished as soon as the read shows it set. A bit that sets after n pulses therefore receives max(n, MIN_PULSES) pulses.
- R6: A bit still 0 after MAX_PULSES pulses is recorded as failed, and the remaining requested bits are still processed.
- R7: After the last bit, one final byte read is made. `error` is raised if any bit failed or if any requested 1 bit reads 0 in that read.
- R8: A command is held stable while `cmd_valid` is high and `cmd_ready` is low. No new command is raised between a transfer and its `rsp_valid`. `cmd_addr` equals the address latched at start.
- R9: A `start` that arrives while a job is running is ignored, and the running job completes unchanged.
- R10: `done` is high for exactly one cycle per job. `error` is cleared in the cycle that accepts `start` and then holds its result until the next accepted start. After reset, `done`, `error` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; taken only when idle |
| addr | input | ADDR_W | Byte address in the fuse array |
| value | input | DATA_W | Bits to be set to 1 |
| done | output | 1 | One-cycle end-of-job pulse |
| error | output | 1 | Job result; held until next start |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_prog | output | 1 | 1 = program pulse on `cmd_bit`, 0 = byte read |
| cmd_addr | output | ADDR_W | Byte address of the command |
| cmd_bit | output | $clog2(DATA_W) | Bit index for a program pulse |
| rsp_valid | input | 1 | Completion of the outstanding command |
| rsp_data | input | DATA_W | Byte read, valid with `rsp_valid` on a read |

## Verification
Two things can happen in the same clock edge: the response to one command retires, and the sequencer raises the next command. The controller model in the bench provokes this by answering after one to three cycles and by sometimes withholding `cmd_ready`. The bench flags any command raised while one is outstanding, and any change to a command while it is stalled. A second `start` is also driven in the middle of running jobs. The per-bit pulse counts and the result must still match the first request.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SCAN,
    ST_BITRD,
    ST_PULSE,
    ST_VERIFY,
    ST_FINAL
  } seq_state_e;

  typedef enum logic [1:0] {
    PT_IDLE,
    PT_REQ,
    PT_WAIT
  } port_state_e;

endpackage

// File: rtl/fps_cmd_port.sv
module fps_cmd_port #(
  parameter int BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             issue_prog,
  input  logic [BIT_W-1:0] issue_bit,
  output logic             can_issue,
  output logic             rsp_fire,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_prog,
  output logic [BIT_W-1:0] cmd_bit,
  input  logic             rsp_valid
);
  import fps_pkg::*;

  port_state_e pst;

  assign rsp_fire  = (pst == PT_WAIT) && rsp_valid;
  assign can_issue = (pst == PT_IDLE) || rsp_fire;
  assign cmd_valid = (pst == PT_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst      <= PT_IDLE;
      cmd_prog <= 1'b0;
      cmd_bit  <= '0;
    end else if (issue && can_issue) begin
      pst      <= PT_REQ;
      cmd_prog <= issue_prog;
      cmd_bit  <= issue_bit;
    end else begin
      case (pst)
        PT_REQ:  if (cmd_ready) pst <= PT_WAIT;
        PT_WAIT: if (rsp_valid) pst <= PT_IDLE;
        default: ;
      endcase
    end
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_prog) && $stable(cmd_bit)));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> can_issue);

endmodule

// File: rtl/fps_pulse_ctr.sv
module fps_pulse_ctr #(
  parameter int MIN_PULSES = 4,
  parameter int MAX_PULSES = 20,
  parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             pre_min,
  output logic             at_max
);

  assign pre_min = (cnt >= CNT_W'(MIN_PULSES - 1));
  assign at_max  = (cnt >= CNT_W'(MAX_PULSES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !at_max) cnt <= cnt + CNT_W'(1);
  end

  // R4
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_PULSES));

  // R4
  no_extra_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && at_max));

endmodule

// File: rtl/fps_bit_pick.sv
module fps_bit_pick #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] pend,
  output logic              any,
  output logic [BIT_W-1:0]  sel
);

  assign any = |pend;

  always_comb begin
    sel = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pend[i]) sel = BIT_W'(i);
    end
  end

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int MIN_PULSES = 4,
  parameter int MAX_PULSES = 20,
  localparam int BIT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] value,
  output logic              done,
  output logic              error,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_prog,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BIT_W-1:0]  cmd_bit,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  import fps_pkg::*;

  localparam int CNT_W = $clog2(MAX_PULSES + 1);

  seq_state_e        st, st_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] handled;
  logic [BIT_W-1:0]  cur_bit;
  logic              fail_q;
  logic              error_q;
  logic              done_q;

  logic              issue, issue_prog;
  logic [BIT_W-1:0]  issue_bit;
  logic              can_issue, rsp_fire;
  logic              cnt_clr, cnt_inc, pre_min, at_max;
  logic [CNT_W-1:0]  cnt;
  logic              pick_any;
  logic [BIT_W-1:0]  pick_sel;
  logic              cur_set;
  logic              no_new;

  assign done     = done_q;
  assign error    = error_q;
  assign cmd_addr = addr_q;
  assign cur_set  = rsp_data[cur_bit];
  assign no_new   = ((~rsp_data & val_q) == '0);

  fps_cmd_port #(.BIT_W(BIT_W)) port_i (
    .clk, .rst_n,
    .issue, .issue_prog, .issue_bit,
    .can_issue, .rsp_fire,
    .cmd_valid, .cmd_ready, .cmd_prog, .cmd_bit,
    .rsp_valid
  );

  fps_pulse_ctr #(.MIN_PULSES(MIN_PULSES), .MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) ctr_i (
    .clk, .rst_n,
    .clr(cnt_clr), .inc(cnt_inc),
    .cnt, .pre_min, .at_max
  );

  fps_bit_pick #(.DATA_W(DATA_W), .BIT_W(BIT_W)) pick_i (
    .pend(val_q & ~handled),
    .any(pick_any),
    .sel(pick_sel)
  );

  always_comb begin
    st_n       = st;
    issue      = 1'b0;
    issue_prog = 1'b0;
    issue_bit  = cur_bit;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        issue = 1'b1;
        st_n  = ST_INIT;
      end
      ST_INIT: if (rsp_fire) st_n = no_new ? ST_IDLE : ST_SCAN;
      ST_SCAN: begin
        issue = 1'b1;
        if (pick_any) begin
          issue_bit = pick_sel;
          st_n      = ST_BITRD;
        end else begin
          st_n = ST_FINAL;
        end
      end
      ST_BITRD: if (rsp_fire) begin
        if (cur_set) begin
          st_n = ST_SCAN;
        end else begin
          issue      = 1'b1;
          issue_prog = 1'b1;
          cnt_clr    = 1'b1;
          st_n       = ST_PULSE;
        end
      end
      ST_PULSE: if (rsp_fire) begin
        cnt_inc = 1'b1;
        issue   = 1'b1;
        if (pre_min) st_n = ST_VERIFY;
        else         issue_prog = 1'b1;
      end
      ST_VERIFY: if (rsp_fire) begin
        if (cur_set || at_max) begin
          st_n = ST_SCAN;
        end else begin
          issue      = 1'b1;
          issue_prog = 1'b1;
          st_n       = ST_PULSE;
        end
      end
      ST_FINAL: if (rsp_fire) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      val_q   <= '0;
      handled <= '0;
      cur_bit <= '0;
      fail_q  <= 1'b0;
      error_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st     <= st_n;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          addr_q  <= addr;
          val_q   <= value;
          handled <= '0;
          fail_q  <= 1'b0;
          error_q <= 1'b0;
        end
        ST_INIT: if (rsp_fire && no_new) done_q <= 1'b1;
        ST_SCAN: if (pick_any) cur_bit <= pick_sel;
        ST_BITRD: if (rsp_fire && cur_set) handled[cur_bit] <= 1'b1;
        ST_VERIFY: if (rsp_fire && (cur_set || at_max)) begin
          handled[cur_bit] <= 1'b1;
          if (!cur_set) fail_q <= 1'b1;
        end
        ST_FINAL: if (rsp_fire) begin
          done_q  <= 1'b1;
          error_q <= fail_q | (|(val_q & ~rsp_data));
        end
        default: ;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && start) |=> ($stable(val_q) && $stable(addr_q)));

  // R5
  verify_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VERIFY) |-> (cnt >= CNT_W'(MIN_PULSES)));

  // R2
  prog_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_prog) |-> val_q[cmd_bit]);

  // R10
  error_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start) |=> !error_q);

endmodule

// File: tb/fuse_prog_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_prog_seq_tb_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int MINP   = 4;
  localparam int MAXP   = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, start, done, error;
  logic [ADDR_W-1:0] addr, cmd_addr;
  logic [DATA_W-1:0] value, rsp_data;
  logic              cmd_valid, cmd_ready, cmd_prog, rsp_valid;
  logic [2:0]        cmd_bit;

  fuse_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSES(MINP), .MAX_PULSES(MAXP)) dut_i (
    .clk, .rst_n, .start, .addr, .value, .done, .error,
    .cmd_valid, .cmd_ready, .cmd_prog, .cmd_addr, .cmd_bit,
    .rsp_valid, .rsp_data
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // controller and fuse byte model
  logic [7:0]        arr;
  int                need [8];
  int                pcnt [8];
  int                nreads, last_bit, proto_err, order_err, addr_err, cyc, lat;
  bit                busy, pend_seen, pp, cap_prog;
  logic [2:0]        pb, cap_bit;
  logic [ADDR_W-1:0] cap_addr, job_addr;

  initial begin
    cmd_ready = 0; rsp_valid = 0; rsp_data = '0; busy = 0; lat = 0; cyc = 0;
    pend_seen = 0; proto_err = 0; order_err = 0; addr_err = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_valid) begin rsp_valid = 0; busy = 0; end
      if (cmd_ready) begin
        cmd_ready = 0; busy = 1; lat = 1 + (cyc % 3);
        if (cap_addr != job_addr) addr_err++;
        if (cap_prog) begin
          pcnt[cap_bit]++;
          if (int'(cap_bit) < last_bit) order_err++;
          last_bit = int'(cap_bit);
          if (pcnt[cap_bit] >= need[cap_bit]) arr[cap_bit] = 1'b1;
        end else begin
          nreads++;
        end
      end else if (busy) begin
        lat--;
        if (lat == 0) begin rsp_valid = 1; rsp_data = arr; end
      end else if (cmd_valid) begin
        if (pend_seen && (cmd_prog != pp || cmd_bit != pb)) proto_err++;
        if (cyc % 3 != 1) begin
          cmd_ready = 1; cap_prog = cmd_prog; cap_bit = cmd_bit; cap_addr = cmd_addr; pend_seen = 0;
        end else begin
          pend_seen = 1; pp = cmd_prog; pb = cmd_bit;
        end
      end
      if (busy && cmd_valid) proto_err++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] val, pre;
    int exp_p [8];
    int exp_reads, t, tot;
    bit exp_fail, skip;
    rst_n = 0; start = 0; addr = '0; value = '0; job_addr = '0;
    repeat (3) @(negedge clk);
    chk(done == 0 && error == 0 && cmd_valid == 0, "R10 reset state", int'({done, error, cmd_valid}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int job = 0; job < 30; job++) begin
      job_addr = ADDR_W'((job * 97 + 5) % 1024);
      if (job == 0)      val = 8'h00;
      else if (job == 1) val = 8'hA5;
      else if (job == 2) val = 8'hFF;
      else               val = 8'((job * 37 + 13) % 256);
      for (int b = 0; b < 8; b++) begin
        if (job == 1) pre[b] = val[b] | (b == 1);
        else          pre[b] = ((job * 3 + b) % 5 == 0);
        need[b] = 1 + ((job * 11 + b * 7) % 24);
        pcnt[b] = 0;
      end
      arr = pre; nreads = 0; last_bit = 0;
      skip = ((val & ~pre) == 8'h00);
      exp_fail = 0;
      exp_reads = skip ? 1 : 2;
      for (int b = 0; b < 8; b++) begin
        exp_p[b] = 0;
        if (!skip && val[b]) begin
          exp_reads++;
          if (!pre[b]) begin
            if (need[b] > MAXP) begin exp_p[b] = MAXP; exp_fail = 1; end
            else exp_p[b] = (need[b] > MINP) ? need[b] : MINP;
            exp_reads += exp_p[b] - MINP + 1;
          end
        end
      end

      @(negedge clk);
      start = 1; addr = job_addr; value = val;
      @(negedge clk);
      start = 0;
      chk(error == 0, "R10 error cleared at start", int'(error), 0);
      if (!skip) begin
        repeat (12) @(negedge clk);
        start = 1; addr = ~job_addr; value = ~val;   // R9: ignored while busy
        @(negedge clk);
        start = 0;
      end
      t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      chk(done == 1, "R10 done seen", int'(done), 1);
      chk(error == exp_fail, "R6/R7 error result", int'(error), int'(exp_fail));
      tot = 0;
      for (int b = 0; b < 8; b++) begin
        tot += pcnt[b];
        chk(pcnt[b] == exp_p[b], "R3/R4/R5/R9 pulses per bit", pcnt[b], exp_p[b]);
      end
      if (skip) chk(tot == 0, "R1 no pulses when nothing new", tot, 0);
      chk(nreads == exp_reads, "R1/R5/R7 read count", nreads, exp_reads);
      chk(order_err == 0, "R2 ascending bit order", order_err, 0);
      chk(proto_err == 0, "R8 handshake rules", proto_err, 0);
      chk(addr_err == 0, "R8 command address", addr_err, 0);
      @(negedge clk);
      chk(done == 0, "R10 done one cycle", int'(done), 0);
      repeat (2) @(negedge clk);
      chk(error == exp_fail, "R10 error held", int'(error), int'(exp_fail));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule